// File: doc/BRIEF.md
# Register-Programmed Event Timer

A free-running 64-bit main counter feeds a parameterised set of comparator channels, three by default. Software programs the block through a flat 64-bit register bus: an address, a write-data word, a write strobe and a combinational read-data word. Each channel compares the counter against its own comparator and raises an interrupt on a match. A channel can fire once or repeat at a fixed period, and it can signal as a one-cycle pulse or as a held level that software acknowledges.

The block sits beside the system interrupt fabric as a timebase. Software first reads the capability word to learn how many channels exist and how long one tick lasts. It then presets the counter while the counter is stopped, programs the channels and starts counting with the global enable. Each channel owns a 32-byte register block. The first channel block starts at byte offset 0x100.

Top module: `evt_timer`

## Requirements
- R1: The read-only capability word at offset 0x000 holds the revision in bits 7:0 and the channel count minus one in bits 12:8. Bit 13 reads 1 (64-bit counter), bits 15:14 read 0, bits 31:16 hold the vendor code and bits 63:32 hold the tick period. Writes to this word change nothing.
- R2: In the global word at offset 0x010, bit 0 is a run enable; every other bit reads as 0. The counter at offset 0x0F0 resets to 0 and rises by exactly one on every clock edge at which run is set.
- R3: A write to the counter loads it only while run is clear. While run is set the write is dropped and counting continues.
- R4: A channel configuration word (channel base + 0x00) stores these writable fields: bit 1 = level (1) or edge (0), bit 2 = interrupt enable, bit 3 = periodic, bit 6 = period-load, bit 8 = 32-bit mode, bits 13:9 = route. Bits 4 and 5 always read 1, bits 15:14 read 0, and bits 63:32 read the fixed route mask.
- R5: The comparator (channel base + 0x08) resets to all ones. A one-shot channel fires in the cycle in which run is set and the counter equals the comparator. Its interrupt output responds one clock later, so at that point the counter reads the comparator value plus one.
- R6: In periodic mode, each firing adds the stored period to the comparator. A comparator write with bit 6 set loads both the comparator and the period and clears bit 6. A comparator write with bit 6 clear updates only the period.
- R7: In 32-bit mode only the low 32 bits of the counter and the comparator take part in the match. Comparator writes keep only the low 32 bits, and the comparator's upper half reads as 0.
- R8: A level channel sets its bit in the status word (offset 0x020, bit n for channel n) when it fires. Writing 1 to the bit clears it, and writing 0 leaves it unchanged. The channel's interrupt output equals its status bit ANDed with its interrupt enable.
- R9: An edge channel drives a one-clock interrupt pulse after each firing and never sets its status bit.
- R10: With the interrupt enable clear, a channel never drives its interrupt output, but a level channel still sets its status bit when it fires.
- R11: The following all read as 0, and writes to them have no effect:
  - unassigned offsets;
  - the two route words at channel base + 0x10 and + 0x18;
  - blocks beyond the last channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 64 | Write data |
| bus_we | input | 1 | Write strobe, taken at the clock edge |
| bus_rdata | output | 64 | Read data for bus_addr, combinational |
| irq | output | NUM_CH | One interrupt line per channel |

## Verification
The bench builds the block with three channels, a 12-bit address, a nonzero route mask and distinctive revision, vendor and tick constants. Every field of the capability word and the upper half of each configuration word can therefore be told apart from 0 or all ones. The three channels are used at the same time in different roles:
- channel 0 covers edge one-shot, disabled-interrupt level and edge periodic;
- channel 1 covers level periodic with acknowledge;
- channel 2 covers 32-bit matching against a counter with a nonzero upper half.

With three channels, the block at 0x160 is the first address past the last channel, so that decode boundary is also exercised.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int unsigned WORD_W = 64;

    // Global register offsets (byte addresses)
    localparam logic [11:0] OFF_CAP     = 12'h000;
    localparam logic [11:0] OFF_GCFG    = 12'h010;
    localparam logic [11:0] OFF_STS     = 12'h020;
    localparam logic [11:0] OFF_CNT     = 12'h0F0;
    localparam logic [11:0] OFF_CH_BASE = 12'h100;
    localparam int unsigned CH_SPAN_LG  = 5;   // 32-byte channel blocks

    typedef enum logic [1:0] {
        W_CFG = 2'd0,
        W_CMP = 2'd1,
        W_RT0 = 2'd2,
        W_RT1 = 2'd3
    } ch_word_e;

    typedef struct packed {
        logic [4:0] route;
        logic       mode32;
        logic       valset;
        logic       periodic;
        logic       inten;
        logic       level;
    } ch_cfg_t;

    function automatic ch_cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
        ch_cfg_t c;
        c.route    = w[13:9];
        c.mode32   = w[8];
        c.valset   = w[6];
        c.periodic = w[3];
        c.inten    = w[2];
        c.level    = w[1];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_to_word(input ch_cfg_t c,
                                                      input logic [31:0] mask);
        return {mask, 16'h0000, 2'b00, c.route, c.mode32, 1'b0, c.valset,
                1'b1, 1'b1, c.periodic, c.inten, c.level, 1'b0};
    endfunction

    function automatic logic [WORD_W-1:0] cap_word(input logic [7:0] rev,
                                                   input int unsigned nch,
                                                   input logic [15:0] vendor,
                                                   input logic [31:0] tick);
        logic [4:0] nm1;
        nm1 = 5'(nch - 1);
        return {tick, vendor, 2'b00, 1'b1, nm1, rev};
    endfunction

endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (en) begin
            count <= count + W'(1);
        end else if (wr) begin
            count <= wdata;
        end
    end

endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_timer_pkg::*;
#(
    parameter logic [31:0] ROUTE_MASK = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] count,
    input  logic              run,
    input  logic              cfg_wr,
    input  ch_cfg_t           cfg_in,
    input  logic              cmp_wr,
    input  logic [WORD_W-1:0] cmp_in,
    input  logic              sts_clr,
    output logic [WORD_W-1:0] cfg_word,
    output logic [WORD_W-1:0] cmp_word,
    output logic              fire,
    output logic              status,
    output logic              irq,
    output ch_cfg_t           cfg,
    output logic [WORD_W-1:0] cmp_q,
    output logic [WORD_W-1:0] per_q
);

    localparam int unsigned HALF = WORD_W / 2;

    logic              match;
    logic              pulse_q;
    logic [WORD_W-1:0] cmp_wval;
    logic [WORD_W-1:0] cmp_adv;
    logic [HALF-1:0]   adv_lo;

    always_comb begin
        if (cfg.mode32) begin
            match    = (count[HALF-1:0] == cmp_q[HALF-1:0]);
            cmp_wval = {{HALF{1'b0}}, cmp_in[HALF-1:0]};
            adv_lo   = cmp_q[HALF-1:0] + per_q[HALF-1:0];
            cmp_adv  = {{HALF{1'b0}}, adv_lo};
        end else begin
            match    = (count == cmp_q);
            cmp_wval = cmp_in;
            adv_lo   = '0;
            cmp_adv  = cmp_q + per_q;
        end
    end

    assign fire = run && match;

    // Configuration, comparator and period state
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            cmp_q <= '1;
            per_q <= '0;
        end else if (cfg_wr) begin
            cfg <= cfg_in;
            if (fire && cfg.periodic) begin
                cmp_q <= cmp_adv;
            end
        end else if (cmp_wr) begin
            if (cfg.periodic) begin
                per_q <= cmp_wval;
                if (cfg.valset) begin
                    cmp_q      <= cmp_wval;
                    cfg.valset <= 1'b0;
                end
            end else begin
                cmp_q <= cmp_wval;
            end
        end else if (fire && cfg.periodic) begin
            cmp_q <= cmp_adv;
        end
    end

    // Interrupt state: level status and edge pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            status  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            if (fire && cfg.level) begin
                status <= 1'b1;
            end else if (sts_clr) begin
                status <= 1'b0;
            end
            pulse_q <= fire && cfg.inten && !cfg.level;
        end
    end

    assign irq      = cfg.level ? (status && cfg.inten) : pulse_q;
    assign cfg_word = cfg_to_word(cfg, ROUTE_MASK);
    assign cmp_word = cfg.mode32 ? {{HALF{1'b0}}, cmp_q[HALF-1:0]} : cmp_q;

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int unsigned NUM_CH     = 3,
    parameter int unsigned ADDR_W     = 12,
    parameter logic [7:0]  REV_ID     = 8'h01,
    parameter logic [15:0] VENDOR_ID  = 16'h7E51,
    parameter logic [31:0] TICK_FS    = 32'd41666667,
    parameter logic [31:0] ROUTE_MASK = 32'h00F0_0C00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [63:0]       bus_wdata,
    input  logic              bus_we,
    output logic [63:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    localparam int unsigned          SEL_W    = ADDR_W - CH_SPAN_LG;
    localparam logic [SEL_W-1:0]     CH_FIRST = SEL_W'(OFF_CH_BASE >> CH_SPAN_LG);
    localparam logic [WORD_W-1:0]    CAP      = cap_word(REV_ID, NUM_CH, VENDOR_ID, TICK_FS);

    logic              run;
    logic              cnt_wr;
    logic [WORD_W-1:0] count;

    logic hit_cap, hit_gcfg, hit_sts, hit_cnt, in_ch;
    logic [SEL_W-1:0] ch_num;
    ch_word_e         ch_word;
    ch_cfg_t          cfg_in;

    logic [NUM_CH-1:0]             ch_fire, ch_sts, ch_level, ch_inten;
    logic [NUM_CH-1:0]             ch_periodic, ch_mode32, ch_cmp_wr;
    logic [NUM_CH-1:0][WORD_W-1:0] ch_cfg_word, ch_cmp_word, ch_cmp, ch_per;

    // Address decode
    always_comb begin
        hit_cap  = (bus_addr == ADDR_W'(OFF_CAP));
        hit_gcfg = (bus_addr == ADDR_W'(OFF_GCFG));
        hit_sts  = (bus_addr == ADDR_W'(OFF_STS));
        hit_cnt  = (bus_addr == ADDR_W'(OFF_CNT));
        ch_num   = bus_addr[ADDR_W-1:CH_SPAN_LG] - CH_FIRST;
        ch_word  = ch_word_e'(bus_addr[4:3]);
        in_ch    = (bus_addr[2:0] == 3'b000)
                && (bus_addr[ADDR_W-1:CH_SPAN_LG] >= CH_FIRST)
                && (ch_num < SEL_W'(NUM_CH));
    end

    assign cfg_in = cfg_from_word(bus_wdata);
    assign cnt_wr = bus_we && hit_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
        end else if (bus_we && hit_gcfg) begin
            run <= bus_wdata[0];
        end
    end

    evt_main_counter #(.W(WORD_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .en    (run),
        .wr    (cnt_wr),
        .wdata (bus_wdata),
        .count (count)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic    sel;
        ch_cfg_t cfg_g;

        assign sel          = in_ch && (ch_num == SEL_W'(g));
        assign ch_cmp_wr[g] = bus_we && sel && (ch_word == W_CMP);

        evt_channel #(.ROUTE_MASK(ROUTE_MASK)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .count    (count),
            .run      (run),
            .cfg_wr   (bus_we && sel && (ch_word == W_CFG)),
            .cfg_in   (cfg_in),
            .cmp_wr   (ch_cmp_wr[g]),
            .cmp_in   (bus_wdata),
            .sts_clr  (bus_we && hit_sts && bus_wdata[g]),
            .cfg_word (ch_cfg_word[g]),
            .cmp_word (ch_cmp_word[g]),
            .fire     (ch_fire[g]),
            .status   (ch_sts[g]),
            .irq      (irq[g]),
            .cfg      (cfg_g),
            .cmp_q    (ch_cmp[g]),
            .per_q    (ch_per[g])
        );

        assign ch_level[g]    = cfg_g.level;
        assign ch_inten[g]    = cfg_g.inten;
        assign ch_periodic[g] = cfg_g.periodic;
        assign ch_mode32[g]   = cfg_g.mode32;
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (hit_cap) begin
            bus_rdata = CAP;
        end else if (hit_gcfg) begin
            bus_rdata = {63'b0, run};
        end else if (hit_sts) begin
            bus_rdata = 64'(ch_sts);
        end else if (hit_cnt) begin
            bus_rdata = count;
        end else if (in_ch) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_num == SEL_W'(i)) begin
                    case (ch_word)
                        W_CFG:   bus_rdata = ch_cfg_word[i];
                        W_CMP:   bus_rdata = ch_cmp_word[i];
                        default: bus_rdata = '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
    parameter int unsigned NUM_CH = 3
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   run,
    input logic                   cnt_wr,
    input logic [63:0]            count,
    input logic [NUM_CH-1:0]      fire,
    input logic [NUM_CH-1:0]      level,
    input logic [NUM_CH-1:0]      inten,
    input logic [NUM_CH-1:0]      periodic,
    input logic [NUM_CH-1:0]      mode32,
    input logic [NUM_CH-1:0]      cmp_wr,
    input logic [NUM_CH-1:0]      status,
    input logic [NUM_CH-1:0]      irq,
    input logic [NUM_CH-1:0][63:0] cmp,
    input logic [NUM_CH-1:0][63:0] per
);

    // R2: a running counter steps by one each clock
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        $past(run) |-> count == $past(count) + 64'd1);

    // R3: a stopped counter that is not written keeps its value
    a_r3_count_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(run) && !$past(cnt_wr)) |-> $stable(count));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R8: a level channel latches its status on a firing
        a_r8_level_sets: assert property (@(posedge clk) disable iff (rst)
            (fire[g] && level[g]) |=> status[g]);

        // R9: an interrupt always has a cause
        a_r9_irq_cause: assert property (@(posedge clk) disable iff (rst)
            irq[g] |-> (status[g] || $past(fire[g])));

        // R10: no interrupt while the enable has been clear
        a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
            (!inten[g] && !$past(inten[g])) |-> !irq[g]);

        // R6: periodic firing advances the comparator by the period
        a_r6_advance: assert property (@(posedge clk) disable iff (rst)
            (fire[g] && periodic[g] && !mode32[g] && !cmp_wr[g])
            |=> cmp[g] == $past(cmp[g]) + $past(per[g]));
    end

endmodule

bind evt_timer evt_timer_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .cnt_wr   (cnt_wr),
    .count    (count),
    .fire     (ch_fire),
    .level    (ch_level),
    .inten    (ch_inten),
    .periodic (ch_periodic),
    .mode32   (ch_mode32),
    .cmp_wr   (ch_cmp_wr),
    .status   (ch_sts),
    .irq      (irq),
    .cmp      (ch_cmp),
    .per      (ch_per)
);

// File: tb/sim_evt_timer.sv
module sim_evt_timer;

    localparam int          CLK_PERIOD = 10;
    localparam int          NCH        = 3;
    localparam logic [7:0]  REV        = 8'h02;
    localparam logic [15:0] VEND       = 16'h5A3C;
    localparam logic [31:0] TICK       = 32'd69841279;
    localparam logic [31:0] RMASK      = 32'h00F0_0C00;
    localparam logic [63:0] CAP_EXP    = {TICK, VEND, 8'h22, REV};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [63:0] bus_rdata;
    logic [NCH-1:0] irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    evt_timer #(
        .NUM_CH(NCH), .ADDR_W(12), .REV_ID(REV), .VENDOR_ID(VEND),
        .TICK_FS(TICK), .ROUTE_MASK(RMASK)
    ) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct packed {
        logic        we;
        logic [11:0] addr;
        logic [63:0] wd;
        logic [63:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 12'h000, 64'h0, CAP_EXP, 4'd1},                       // R1
        '{1'b0, 12'h010, 64'h0, 64'h0, 4'd2},                         // R2
        '{1'b0, 12'h020, 64'h0, 64'h0, 4'd8},                         // R8
        '{1'b0, 12'h0F0, 64'h0, 64'h0, 4'd2},                         // R2
        '{1'b0, 12'h100, 64'h0, {RMASK, 32'h30}, 4'd4},               // R4
        '{1'b0, 12'h108, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 4'd5},       // R5
        '{1'b0, 12'h110, 64'h0, 64'h0, 4'd11},                        // R11
        '{1'b0, 12'h008, 64'h0, 64'h0, 4'd11},                        // R11
        '{1'b0, 12'h160, 64'h0, 64'h0, 4'd11},                        // R11
        '{1'b1, 12'h010, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0, 4'd2},       // R2
        '{1'b1, 12'h0F0, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 4'd3}, // R3
        '{1'b1, 12'h100, 64'hFFFF_FFFF_FFFF_FFFF, {RMASK, 32'h3F7E}, 4'd4},       // R4
        '{1'b1, 12'h108, 64'hDEAD_BEEF_0000_0040, 64'h40, 4'd7},      // R7
        '{1'b0, 12'h100, 64'h0, {RMASK, 32'h3F3E}, 4'd6},             // R6
        '{1'b1, 12'h100, 64'h0, {RMASK, 32'h30}, 4'd4},               // R4
        '{1'b0, 12'h108, 64'h0, 64'h40, 4'd7},                        // R7
        '{1'b1, 12'h020, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 4'd8},       // R8
        '{1'b1, 12'h000, 64'hFFFF_FFFF_FFFF_FFFF, CAP_EXP, 4'd1},     // R1
        '{1'b1, 12'h168, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 4'd11}       // R11
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic poll_irq(input int idx, input int limit, output bit seen);
        seen = 0;
        for (int k = 0; k < limit; k++) begin
            @(negedge clk);
            #1;
            if (irq[idx]) begin
                seen = 1;
                break;
            end
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [63:0] d;
        logic [63:0] c0;
        bit seen;
        int highs;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R9 irq low after reset", 64'(irq), 64'h0);

        // Table walk: register access, reset values, masks
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].we) wr(VECS[i].addr, VECS[i].wd);
            rd(VECS[i].addr, d);
            chk($sformatf("R%0d table entry %0d", VECS[i].req, i), d, VECS[i].exp);
        end

        // R5 / R9: edge one-shot on channel 0
        wr(12'h0F0, 64'h0);
        wr(12'h100, 64'h4);
        wr(12'h108, 64'd5);
        wr(12'h010, 64'h1);
        poll_irq(0, 40, seen);
        chk("R5 one-shot fired", 64'(seen), 64'h1);
        rd(12'h0F0, d);
        chk("R5 counter at interrupt", d, 64'd6);
        @(negedge clk);
        #1;
        chk("R9 pulse lasts one clock", 64'(irq[0]), 64'h0);
        rd(12'h020, d);
        chk("R9 edge leaves status clear", d, 64'h0);
        wr(12'h010, 64'h0);
        wr(12'h100, 64'h0);

        // R6 / R8: level periodic on channel 1
        wr(12'h0F0, 64'h0);
        wr(12'h120, 64'h4E);
        wr(12'h128, 64'd4);
        rd(12'h120, d);
        chk("R6 period-load bit self-clears", d, {RMASK, 32'h3E});
        wr(12'h010, 64'h1);
        poll_irq(1, 40, seen);
        chk("R8 level irq raised", 64'(seen), 64'h1);
        rd(12'h0F0, d);
        chk("R5 periodic first hit timing", d, 64'd5);
        rd(12'h128, d);
        chk("R6 comparator advanced", d, 64'd8);
        rd(12'h020, d);
        chk("R8 status bit set", d, 64'h2);
        wr(12'h020, 64'h2);
        rd(12'h020, d);
        chk("R8 write-1 clears", d, 64'h0);
        chk("R8 irq follows status", 64'(irq[1]), 64'h0);
        poll_irq(1, 40, seen);
        rd(12'h0F0, d);
        chk("R6 second period hit", d, 64'd9);
        rd(12'h128, d);
        chk("R6 comparator advanced again", d, 64'd12);
        wr(12'h020, 64'h0);
        rd(12'h020, d);
        chk("R8 write-0 leaves status", d, 64'h2);
        chk("R8 irq still held", 64'(irq[1]), 64'h1);
        wr(12'h010, 64'h0);
        wr(12'h120, 64'h0);
        wr(12'h020, 64'h7);

        // R7: 32-bit match on channel 2 with nonzero counter upper half
        wr(12'h0F0, 64'h1_0000_0010);
        wr(12'h140, 64'h104);
        wr(12'h148, 64'hFFFF_FFFF_0000_0020);
        rd(12'h148, d);
        chk("R7 comparator upper half zero", d, 64'h20);
        wr(12'h010, 64'h1);
        poll_irq(2, 60, seen);
        chk("R7 32-bit match fired", 64'(seen), 64'h1);
        rd(12'h0F0, d);
        chk("R7 match on low half", d, 64'h1_0000_0021);
        wr(12'h010, 64'h0);
        wr(12'h140, 64'h0);

        // R10: level channel with interrupt disabled
        wr(12'h0F0, 64'h0);
        wr(12'h100, 64'h2);
        wr(12'h108, 64'd3);
        wr(12'h010, 64'h1);
        highs = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            #1;
            if (irq[0]) highs++;
        end
        chk("R10 no irq while disabled", 64'(highs), 64'h0);
        rd(12'h020, d);
        chk("R10 status still set", d, 64'h1);
        wr(12'h100, 64'h6);
        chk("R8 irq on enabling with status", 64'(irq[0]), 64'h1);
        wr(12'h020, 64'h1);
        wr(12'h100, 64'h0);

        // R3: counter write dropped while running
        rd(12'h0F0, c0);
        wr(12'h0F0, 64'h0);
        rd(12'h0F0, d);
        chk("R3 write ignored while running", d, c0 + 64'd2);
        wr(12'h010, 64'h0);

        // R6: period-only write, edge periodic on channel 0
        wr(12'h0F0, 64'h0);
        wr(12'h100, 64'h4C);
        wr(12'h108, 64'd10);
        wr(12'h100, 64'h0C);
        wr(12'h108, 64'd3);
        rd(12'h108, d);
        chk("R6 period-only write keeps comparator", d, 64'd10);
        wr(12'h010, 64'h1);
        poll_irq(0, 40, seen);
        rd(12'h0F0, d);
        chk("R6 first periodic edge", d, 64'd11);
        poll_irq(0, 40, seen);
        rd(12'h0F0, d);
        chk("R6 new period applied", d, 64'd14);
        wr(12'h010, 64'h0);

        finish_run();
    end

endmodule